// File: doc/BRIEF.md
# GPIO Port with Atomic Set/Clear

This block is a general-purpose I/O port of 8, 16 or 32 pins. A simple synchronous register bus reaches it. The bus has a 4-bit word address, a write strobe, write data that is two pin-words wide, and combinational read data. The block gives each pin a direction, an output value, a choice of open-drain or push-pull drive, and three pad configuration bits: pull enable, pull direction and drive strength. The pad logic outside the block consumes those three bits.

The output value can be written whole. It can also be changed through write-only set, clear and toggle words, and through a combined word that carries a set mask and a clear mask at once. Software can therefore change any subset of pins in one bus write, with no read-modify-write.

Every pad input passes through a two-flop synchronizer. Each pin can optionally select a glitch filter that accepts a new level only once it has held for `FLT_LEN` clocks. The resulting level can be read back. It also feeds per-pin edge detectors, which set sticky status bits. Software clears a status bit by writing 1 to it, and the OR of all status bits is the interrupt line.

Top module: `gpio_port`

## Requirements
- R1: After reset every readable register reads 0, `pad_oe_o`, `pad_out_o` and the pad configuration outputs are 0, and `irq_o` is 0.
- R2: Address 0 holds the direction word, where 1 means output. A pin whose direction bit is 0 never has its `pad_oe_o` bit asserted.
- R3: At address 2, a write sets every output bit (address 1) whose write-data bit is 1 and leaves the others unchanged. Address 2 reads as 0.
- R4: At address 3, a write clears each output bit whose write-data bit is 1. At address 4, a write inverts each output bit whose write-data bit is 1. Other bits are unchanged, and both addresses read as 0.
- R5: At address 5, the low pin-word of the write data is a set mask and the high pin-word is a clear mask. A bit named in both masks ends at 0.
- R6: Address 6 selects open-drain per pin. For an open-drain output pin, an output value of 1 deasserts `pad_oe_o`, and a value of 0 drives `pad_out_o` low with `pad_oe_o` asserted. For a push-pull output pin, `pad_out_o` equals the output value.
- R7: Address 7 reads the pin level and ignores writes. With the filter off, a pad change is visible there two clocks after it is applied.
- R8: Address 8 enables the filter per pin. With the filter on, a level change is accepted only after the synchronized input has differed from the accepted level for `FLT_LEN` consecutive clocks, so shorter pulses never appear.
- R9: Addresses 9, 10 and 11 hold the interrupt enable, rising-edge select and falling-edge select words. A selected edge on an enabled pin sets its sticky status bit (address 12), one clock after the level changes at address 7. Writing 1 to a status bit clears it, and a new event in the same clock wins over the clear.
- R10: `irq_o` is high exactly when at least one status bit is set. It falls only after a write to address 12.
- R11: Addresses 13, 14 and 15 hold the pull-enable, pull-up and drive-strength words, which appear unchanged on `pad_pull_en_o`, `pad_pull_up_o` and `pad_drive_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Register word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 2*NPINS | Write data; high half used only by the combined set/clear word |
| bus_rdata_o | output | 2*NPINS | Read data for the addressed register, zero-extended |
| pad_in_i | input | NPINS | Raw pad input levels |
| pad_out_o | output | NPINS | Level driven toward each pad |
| pad_oe_o | output | NPINS | Pad output enable |
| pad_pull_en_o | output | NPINS | Pull resistor enable configuration |
| pad_pull_up_o | output | NPINS | Pull direction, 1 = up |
| pad_drive_o | output | NPINS | Drive strength select |
| irq_o | output | 1 | Interrupt, OR of sticky status |

## Verification
The bound assertions check, on every clock, the per-bit effect of set, clear and combined writes on the output word. They also check that the output enable stays off for input pins and for released open-drain pins, that status never rises on a disabled pin, and that the interrupt drops only after a clear write. What only the bench scenarios can show is the timing of the input path: the two-clock synchronizer delay, the filter rejecting a short pulse and accepting a held level on exactly the `FLT_LEN`-th clock, the choice of edge polarity, and a status set racing a clear in the same clock. A behavioural model is compared against all outputs on every clock alongside these scenarios.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [3:0] {
    REG_DIR    = 4'd0,
    REG_OUT    = 4'd1,
    REG_SET    = 4'd2,
    REG_CLR    = 4'd3,
    REG_TGL    = 4'd4,
    REG_SETCLR = 4'd5,
    REG_OD     = 4'd6,
    REG_IN     = 4'd7,
    REG_FLT    = 4'd8,
    REG_IEN    = 4'd9,
    REG_IRISE  = 4'd10,
    REG_IFALL  = 4'd11,
    REG_ISTAT  = 4'd12,
    REG_PULLEN = 4'd13,
    REG_PULLUP = 4'd14,
    REG_DRIVE  = 4'd15
  } gpio_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] d_i,
  output logic [NPINS-1:0] q_o
);
  logic [NPINS-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int unsigned NPINS   = 16,
  parameter int unsigned FLT_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] d_i,
  input  logic [NPINS-1:0] en_i,
  output logic [NPINS-1:0] q_o
);
  localparam int unsigned CNT_W = (FLT_LEN > 2) ? $clog2(FLT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FLT_LEN - 1);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic             acc_q;
    logic [CNT_W-1:0] cnt_q;

    // accept a new level only after FLT_LEN consecutive differing samples
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q <= 1'b0;
        cnt_q <= '0;
      end else if (d_i[g] != acc_q) begin
        if (cnt_q == CNT_LAST) begin
          acc_q <= d_i[g];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end

    assign q_o[g] = en_i[g] ? acc_q : d_i[g];
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] ien_i,
  input  logic [NPINS-1:0] rise_i,
  input  logic [NPINS-1:0] fall_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] stat_o,
  output logic             irq_o
);
  logic [NPINS-1:0] prev_q, stat_q, hit;

  assign hit = ien_i & ((lvl_i & ~prev_q & rise_i) | (~lvl_i & prev_q & fall_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl_i;
      stat_q <= (stat_q & ~clr_i) | hit;  // new event beats clear
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = |stat_q;
endmodule

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  gpio_reg_e          addr_i,
  input  logic [2*NPINS-1:0] wdata_i,
  input  logic [NPINS-1:0]   dir_i,
  input  logic [NPINS-1:0]   od_i,
  output logic [NPINS-1:0]   out_o,
  output logic [NPINS-1:0]   pad_out_o,
  output logic [NPINS-1:0]   pad_oe_o
);
  logic [NPINS-1:0] wd_set, wd_clr, out_q, out_d;

  assign wd_set = wdata_i[NPINS-1:0];
  assign wd_clr = wdata_i[2*NPINS-1:NPINS];

  always_comb begin
    out_d = out_q;
    if (we_i) begin
      case (addr_i)
        REG_OUT:    out_d = wd_set;
        REG_SET:    out_d = out_q | wd_set;
        REG_CLR:    out_d = out_q & ~wd_set;
        REG_TGL:    out_d = out_q ^ wd_set;
        REG_SETCLR: out_d = (out_q | wd_set) & ~wd_clr;
        default:    out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  // open-drain: only a 0 is driven, a 1 releases the pad
  assign pad_oe_o  = dir_i & ~(od_i & out_q);
  assign pad_out_o = out_q & ~od_i;
  assign out_o     = out_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS   = 16,
  parameter int unsigned FLT_LEN = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         bus_addr_i,
  input  logic               bus_we_i,
  input  logic [2*NPINS-1:0] bus_wdata_i,
  output logic [2*NPINS-1:0] bus_rdata_o,
  input  logic [NPINS-1:0]   pad_in_i,
  output logic [NPINS-1:0]   pad_out_o,
  output logic [NPINS-1:0]   pad_oe_o,
  output logic [NPINS-1:0]   pad_pull_en_o,
  output logic [NPINS-1:0]   pad_pull_up_o,
  output logic [NPINS-1:0]   pad_drive_o,
  output logic               irq_o
);
  gpio_reg_e        reg_sel;
  logic [NPINS-1:0] wd_lo;
  logic [NPINS-1:0] dir_q, od_q, flt_q, ien_q, rise_q, fall_q, pen_q, pup_q, drv_q;
  logic [NPINS-1:0] out_q, sync_lvl, pin_lvl, stat_q, stat_clr, rd_word;

  assign reg_sel = gpio_reg_e'(bus_addr_i);
  assign wd_lo   = bus_wdata_i[NPINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      od_q   <= '0;
      flt_q  <= '0;
      ien_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      pen_q  <= '0;
      pup_q  <= '0;
      drv_q  <= '0;
    end else if (bus_we_i) begin
      case (reg_sel)
        REG_DIR:    dir_q  <= wd_lo;
        REG_OD:     od_q   <= wd_lo;
        REG_FLT:    flt_q  <= wd_lo;
        REG_IEN:    ien_q  <= wd_lo;
        REG_IRISE:  rise_q <= wd_lo;
        REG_IFALL:  fall_q <= wd_lo;
        REG_PULLEN: pen_q  <= wd_lo;
        REG_PULLUP: pup_q  <= wd_lo;
        REG_DRIVE:  drv_q  <= wd_lo;
        default: ;
      endcase
    end
  end

  gpio_in_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (sync_lvl)
  );

  gpio_in_filter #(.NPINS(NPINS), .FLT_LEN(FLT_LEN)) u_flt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_lvl),
    .en_i  (flt_q),
    .q_o   (pin_lvl)
  );

  assign stat_clr = (bus_we_i && reg_sel == REG_ISTAT) ? wd_lo : '0;

  gpio_edge_irq #(.NPINS(NPINS)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_lvl),
    .ien_i (ien_q),
    .rise_i(rise_q),
    .fall_i(fall_q),
    .clr_i (stat_clr),
    .stat_o(stat_q),
    .irq_o (irq_o)
  );

  gpio_out_ctrl #(.NPINS(NPINS)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .addr_i   (reg_sel),
    .wdata_i  (bus_wdata_i),
    .dir_i    (dir_q),
    .od_i     (od_q),
    .out_o    (out_q),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o)
  );

  always_comb begin
    case (reg_sel)
      REG_DIR:    rd_word = dir_q;
      REG_OUT:    rd_word = out_q;
      REG_OD:     rd_word = od_q;
      REG_IN:     rd_word = pin_lvl;
      REG_FLT:    rd_word = flt_q;
      REG_IEN:    rd_word = ien_q;
      REG_IRISE:  rd_word = rise_q;
      REG_IFALL:  rd_word = fall_q;
      REG_ISTAT:  rd_word = stat_q;
      REG_PULLEN: rd_word = pen_q;
      REG_PULLUP: rd_word = pup_q;
      REG_DRIVE:  rd_word = drv_q;
      default:    rd_word = '0;  // write-only words
    endcase
  end

  assign bus_rdata_o   = {{NPINS{1'b0}}, rd_word};
  assign pad_pull_en_o = pen_q;
  assign pad_pull_up_o = pup_q;
  assign pad_drive_o   = drv_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [3:0]         bus_addr_i,
  input logic               bus_we_i,
  input logic [2*NPINS-1:0] bus_wdata_i,
  input logic [NPINS-1:0]   dir_q,
  input logic [NPINS-1:0]   od_q,
  input logic [NPINS-1:0]   out_q,
  input logic [NPINS-1:0]   ien_q,
  input logic [NPINS-1:0]   stat_q,
  input logic [NPINS-1:0]   pad_out_o,
  input logic [NPINS-1:0]   pad_oe_o,
  input logic               irq_o
);
  logic [NPINS-1:0] m_lo, m_hi;
  logic wr_set, wr_clr, wr_sc, wr_stat;

  assign m_lo    = bus_wdata_i[NPINS-1:0];
  assign m_hi    = bus_wdata_i[2*NPINS-1:NPINS];
  assign wr_set  = bus_we_i && bus_addr_i == REG_SET;
  assign wr_clr  = bus_we_i && bus_addr_i == REG_CLR;
  assign wr_sc   = bus_we_i && bus_addr_i == REG_SETCLR;
  assign wr_stat = bus_we_i && bus_addr_i == REG_ISTAT;

  AST_OE_NEEDS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~dir_q) == '0);  // R2

  AST_OD_RELEASES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od_q & out_q & pad_oe_o) == '0);  // R6

  AST_OD_NEVER_DRIVES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od_q & pad_oe_o & pad_out_o) == '0);  // R6

  AST_SET_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((out_q & $past(m_lo)) == $past(m_lo)));  // R3

  AST_SET_KEEPS_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> (((out_q ^ $past(out_q)) & ~$past(m_lo)) == '0));  // R3

  AST_CLR_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((out_q & $past(m_lo)) == '0));  // R4

  AST_CLR_KEEPS_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> (((out_q ^ $past(out_q)) & ~$past(m_lo)) == '0));  // R4

  AST_SETCLR_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sc |=> ((out_q & $past(m_hi)) == '0));  // R5

  AST_STAT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~$past(stat_q) & ~$past(ien_q)) == '0);  // R9

  AST_IRQ_FALLS_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_stat));  // R10
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_addr_i (bus_addr_i),
  .bus_we_i   (bus_we_i),
  .bus_wdata_i(bus_wdata_i),
  .dir_q      (dir_q),
  .od_q       (od_q),
  .out_q      (out_q),
  .ien_q      (ien_q),
  .stat_q     (stat_q),
  .pad_out_o  (pad_out_o),
  .pad_oe_o   (pad_oe_o),
  .irq_o      (irq_o)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  localparam int N  = 16;
  localparam int FL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]     addr = '0;
  logic           we = 1'b0;
  logic [2*N-1:0] wd = '0;
  logic [N-1:0]   pad_in = '0;
  logic [2*N-1:0] rdata;
  logic [N-1:0]   pad_out, pad_oe, pen, pup, drv;
  logic           irq;

  gpio_port #(.NPINS(N), .FLT_LEN(FL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wd), .bus_rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pull_en_o(pen),
    .pad_pull_up_o(pup), .pad_drive_o(drv), .irq_o(irq)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [N-1:0] m_dir, m_out, m_od, m_flt, m_ien, m_ris, m_fal, m_stat;
  logic [N-1:0] m_pe, m_pu, m_dr, m_acc, m_prev;
  logic [N-1:0] hist[$];
  int m_run[N];

  function automatic logic [N-1:0] m_seen();
    logic [N-1:0] s2 = hist[0];
    for (int i = 0; i < N; i++) m_seen[i] = m_flt[i] ? m_acc[i] : s2[i];
  endfunction

  function automatic logic [2*N-1:0] m_rd();
    logic [N-1:0] v;
    case (addr)
      0: v = m_dir;  1: v = m_out;  6: v = m_od;  7: v = m_seen();
      8: v = m_flt;  9: v = m_ien;  10: v = m_ris; 11: v = m_fal;
      12: v = m_stat; 13: v = m_pe; 14: v = m_pu; 15: v = m_dr;
      default: v = '0;
    endcase
    return {{N{1'b0}}, v};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_dir, m_out, m_od, m_flt, m_ien, m_ris, m_fal, m_stat} = '0;
      {m_pe, m_pu, m_dr, m_acc, m_prev} = '0;
      hist = '{'0, '0};
      for (int i = 0; i < N; i++) m_run[i] = 0;
    end else begin
      logic [N-1:0] lv, lo, hi, hit, s2, nacc;
      lv = m_seen();
      lo = wd[N-1:0];
      hi = wd[2*N-1:N];
      s2 = hist[0];
      hit = m_ien & ((lv & ~m_prev & m_ris) | (~lv & m_prev & m_fal));
      m_stat = (m_stat & ~((we && addr == 12) ? lo : '0)) | hit;
      m_prev = lv;
      nacc = m_acc;
      for (int i = 0; i < N; i++) begin
        if (s2[i] != m_acc[i]) begin
          if (m_run[i] == FL - 1) begin nacc[i] = s2[i]; m_run[i] = 0; end
          else m_run[i]++;
        end else m_run[i] = 0;
      end
      m_acc = nacc;
      void'(hist.pop_front());
      hist.push_back(pad_in);
      if (we) begin
        case (addr)
          0: m_dir = lo;  1: m_out = lo;  2: m_out = m_out | lo;
          3: m_out = m_out & ~lo;  4: m_out = m_out ^ lo;
          5: m_out = (m_out | lo) & ~hi;
          6: m_od = lo;   8: m_flt = lo;  9: m_ien = lo;
          10: m_ris = lo; 11: m_fal = lo; 13: m_pe = lo;
          14: m_pu = lo;  15: m_dr = lo;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "pad_oe", pad_oe, m_dir & ~(m_od & m_out));
      chk("R6", "pad_out", pad_out, m_out & ~m_od);
      chk("R10", "irq", irq, |m_stat);
      chk("R7/R8/R9", "rdata", rdata, m_rd());
      chk("R11", "padcfg", {pen, pup, drv}, {m_pe, m_pu, m_dr});
    end
  end

  task automatic wr(input int a, input logic [2*N-1:0] d);
    @(negedge clk); #1;
    addr = 4'(a); we = 1'b1; wd = d;
    @(negedge clk); #1;
    we = 1'b0; wd = '0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [N-1:0] exp);
    @(negedge clk); #1;
    addr = 4'(a);
    #2;
    chk(req, "read", rdata, {{N{1'b0}}, exp});
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "oe in reset", pad_oe, '0);
    chk("R1", "irq in reset", irq, '0);
    #1 rst_n = 1'b1;
    for (int a = 0; a < 16; a++) rd_chk("R1", a, '0);
    chk("R1", "padcfg after reset", {pen, pup, drv, pad_out}, '0);

    // R2 direction
    wr(1, 32'h0000_00f0);
    wr(0, 32'h0000_ffff);
    @(negedge clk); #2 chk("R2", "pad_out", pad_out, 16'h00f0);
    chk("R2", "oe all out", pad_oe, 16'hffff);
    wr(0, 32'h0000_00ff);
    @(negedge clk); #2 chk("R2", "oe low byte", pad_oe, 16'h00ff);
    wr(0, 32'h0000_ffff);

    // R3 set, R4 clear/toggle, R5 combined
    wr(2, 32'h0000_0f03);
    rd_chk("R3", 1, 16'h0ff3);
    rd_chk("R3", 2, 16'h0000);
    wr(3, 32'h0000_0030);
    rd_chk("R4", 1, 16'h0fc3);
    wr(4, 32'h0000_ffff);
    rd_chk("R4", 1, 16'hf03c);
    rd_chk("R4", 3, 16'h0000);
    wr(5, 32'h0f0f_00ff);
    rd_chk("R5", 1, 16'hf0f0);

    // R6 open drain
    wr(6, 32'h0000_00ff);
    @(negedge clk); #2 chk("R6", "oe od", pad_oe, 16'hff0f);
    chk("R6", "out od", pad_out, 16'hf000);
    wr(6, 32'h0000_0000);

    // R7 write ignored, then sync latency
    wr(7, 32'h0000_ffff);
    rd_chk("R7", 7, 16'h0000);
    @(negedge clk); #1 pad_in[0] = 1'b1;
    @(negedge clk); #2 chk("R7", "in after 1 clk", rdata[0], 1'b0);
    @(negedge clk); #2 chk("R7", "in after 2 clk", rdata[0], 1'b1);

    // R8 filter on pin 1
    wr(8, 32'h0000_0002);
    addr = 4'd7;
    @(negedge clk); #1 pad_in[1] = 1'b1;
    repeat (2) @(negedge clk);
    #1 pad_in[1] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #2 chk("R8", "glitch rejected", rdata[1], 1'b0);
    end
    @(negedge clk); #1 pad_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    #2 chk("R8", "held 5", rdata[1], 1'b0);
    @(negedge clk); #2 chk("R8", "held 6", rdata[1], 1'b1);

    // R9 / R10 edge status
    wr(9, 32'h0000_00f0);
    wr(10, 32'h0000_0050);
    wr(11, 32'h0000_0060);
    addr = 4'd12;
    @(negedge clk); #1 pad_in[4] = 1'b1;
    repeat (2) @(negedge clk);
    #2 chk("R10", "irq before", irq, 1'b0);
    @(negedge clk); #2 chk("R10", "irq set", irq, 1'b1);
    chk("R9", "rise pin4", rdata, 32'h0000_0010);
    @(negedge clk); #1 pad_in[5] = 1'b1; pad_in[8] = 1'b1;
    rd_chk("R9", 12, 16'h0010);
    repeat (3) @(negedge clk);
    rd_chk("R9", 12, 16'h0010);
    @(negedge clk); #1 pad_in[5] = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R9", 12, 16'h0030);
    @(negedge clk); #1 pad_in[6] = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R9", 12, 16'h0070);
    wr(12, 32'h0000_0030);
    rd_chk("R9", 12, 16'h0040);
    @(negedge clk); #2 chk("R10", "irq held", irq, 1'b1);
    wr(12, 32'h0000_0040);
    rd_chk("R9", 12, 16'h0000);
    @(negedge clk); #2 chk("R10", "irq clear", irq, 1'b0);
    // set beats clear in the same clock
    @(negedge clk); #1 pad_in[6] = 1'b0;
    @(negedge clk);
    wr(12, 32'h0000_0040);
    rd_chk("R9", 12, 16'h0040);
    wr(12, 32'h0000_ffff);
    rd_chk("R9", 12, 16'h0000);

    // R11 pad configuration
    wr(13, 32'h0000_1234);
    wr(14, 32'h0000_abcd);
    wr(15, 32'h0000_00ff);
    @(negedge clk); #2 chk("R11", "padcfg", {pen, pup, drv}, {16'h1234, 16'habcd, 16'h00ff});
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule